// File: doc/BRIEF.md
# Alarm Time-Match and Interrupt Request Unit

This block decides when a calendar alarm is due. It holds four alarm registers: minute, hour, day of month and day of week. Each register has a per-field ignore bit. On every time-increment strobe from the external time counters, the block compares the updated BCD time against the fields that take part. If all of them agree, it sets a sticky alarm flag. The flag stays set until a host write clears it.

The block also keeps a timer flag, which an external countdown's expiry pulse sets. It merges the two flags with their interrupt enables into an open-drain interrupt request. The output says when the pad must pull the shared active-low interrupt line down. At all other times the pad releases the line.

The host reaches the block through a simple write port with a 3-bit register select. Select 0 is the control/status word. Selects 1 to 4 are the minute, hour, day and weekday alarm registers. Other selects are ignored.

Top module: `alarm_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, all four alarm registers hold 0x80 (field ignored), both flags are 0, both interrupt enables are 0 and `irq_pull_low` is 0.
- R2: In each alarm register, bit 7 = 0 puts that field into the comparison and bit 7 = 1 leaves it out. Only the field bits are compared: bits 6:0 for minute (BCD 0-59), 5:0 for hour (0-23), 5:0 for day (1-31) and 2:0 for weekday (0-6). Other register bits have no effect.
- R3: When `tick` is high at clock edge k, the time inputs sampled at edge k+1 are compared. On a match of every compared field, `alarm_flag` reads 1 after edge k+1.
- R4: The alarm flag never sets without a preceding `tick`. An alarm-register write that makes the current time match does not set it.
- R5: When all four alarm registers have bit 7 = 1, the alarm flag never sets.
- R6: Once set, the alarm flag stays 1 until a control/status write with bit 0 = 0. After clearing, only a later matching tick sets it again.
- R7: A control/status write ANDs the alarm flag with bit 0 and the timer flag with bit 1. Writing 1 to a flag's bit leaves that flag unchanged.
- R8: If a set event and a clearing write fall on the same edge, the flag ends up set.
- R9: A high `tmr_expire` at an edge sets `timer_flag` after that edge.
- R10: A control/status write loads the alarm interrupt enable from bit 4 and the timer interrupt enable from bit 5. `irq_pull_low` = (alarm_flag AND alarm enable) OR (timer_flag AND timer enable). With both enables 0, the line is released whatever the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday, 0-6 |
| tick | input | 1 | Time-increment strobe; time inputs are updated for the following edge |
| tmr_expire | input | 1 | Countdown expiry pulse; sets the timer flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control/status, 1 minute, 2 hour, 3 day, 4 weekday alarm |
| wr_data | input | 8 | Write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| timer_flag | output | 1 | Sticky timer flag |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt line low, 0 = release it |

## Verification
The hardest case to reach from the ports is a set event and a clearing write landing on the same edge. To reach it, the bench raises `tick` with a matching time and issues the clearing control write exactly one cycle later. The later write lands on the edge where the delayed strobe is evaluated.

A second hard case is a match that arises without an increment. The bench covers it by loading an alarm register with the minute already on the inputs. It then confirms that the flag stays 0 until the next strobe.

// File: rtl/alarm_irq_pkg.sv
// Package: shared constants and helpers for the alarm interrupt unit.
// Assumes BCD time fields no wider than one byte.
package alarm_irq_pkg;

    localparam int REG_W       = 8;
    localparam int SEL_W       = 3;
    localparam int NUM_FIELDS  = 4;
    localparam int IGN_BIT     = REG_W - 1;

    // Register select codes on the write port.
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MIN  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HOUR = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DAY  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_WDAY = 3'd4;

    // Control/status bit positions.
    localparam int CB_AFLAG = 0;
    localparam int CB_TFLAG = 1;
    localparam int CB_AIE   = 4;
    localparam int CB_TIE   = 5;

    typedef enum logic [1:0] {
        FLD_MIN  = 2'd0,
        FLD_HOUR = 2'd1,
        FLD_DAY  = 2'd2,
        FLD_WDAY = 2'd3
    } field_e;

    // Width in bits of the BCD value for each field.
    function automatic int field_width(input int idx);
        case (idx)
            0:       return 7;
            1:       return 6;
            2:       return 6;
            default: return 3;
        endcase
    endfunction

    // Mask selecting the compared bits of a field.
    function automatic logic [REG_W-1:0] field_mask(input int idx);
        logic [REG_W-1:0] m;
        m = '0;
        for (int b = 0; b < REG_W; b++) begin
            if (b < field_width(idx)) m[b] = 1'b1;
        end
        return m;
    endfunction

    // Reset value of an alarm register: field left out of the comparison.
    localparam logic [REG_W-1:0] ALARM_RST = {1'b1, {(REG_W-1){1'b0}}};

endpackage

// File: rtl/alarm_cfg_regs.sv
// Module: alarm_cfg_regs
// Holds the four alarm registers and the two interrupt enables.
// Assumes one write per cycle; unknown selects are dropped.
module alarm_cfg_regs
    import alarm_irq_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = REG_W,
    parameter int AW = SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     alm_val [NF],
    output logic [NF-1:0]     alm_ign,
    output logic              aie,
    output logic              tie
);

    localparam int IB = DW - 1;

    logic ctrl_wr;

    // Decode a control/status write.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == SEL_CTRL);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_alm
            localparam logic [AW-1:0] MY_SEL = AW'(gi + 1);
            logic [DW-1:0] val_q;

            // Load this alarm register on a write to its select.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= ALARM_RST;
                end else if (wr_en && (wr_addr == MY_SEL)) begin
                    val_q <= wr_data;
                end
            end

            // Expose value and ignore bit.
            always_comb begin
                alm_val[gi] = val_q;
                alm_ign[gi] = val_q[IB];
            end
        end
    endgenerate

    // Interrupt enables load from the control/status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aie <= 1'b0;
            tie <= 1'b0;
        end else if (ctrl_wr) begin
            aie <= wr_data[CB_AIE];
            tie <= wr_data[CB_TIE];
        end
    end

endmodule

// File: rtl/alarm_field_cmp.sv
// Module: alarm_field_cmp
// Compares each current time field with its alarm register under the
// field mask; combinational. Assumes registers hold BCD in the low bits.
module alarm_field_cmp
    import alarm_irq_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = REG_W
) (
    input  logic [DW-1:0] cur_val [NF],
    input  logic [DW-1:0] alm_val [NF],
    input  logic [NF-1:0] alm_ign,
    output logic          all_hit
);

    logic [NF-1:0] fld_ok;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_cmp
            localparam logic [DW-1:0] MASK = field_mask(gi);

            // A field passes when ignored or when its masked bits agree.
            always_comb begin
                fld_ok[gi] = alm_ign[gi] ||
                             ((cur_val[gi] & MASK) == (alm_val[gi] & MASK));
            end
        end
    endgenerate

    // Hit needs every field to pass and at least one field compared.
    always_comb begin
        all_hit = (&fld_ok) && !(&alm_ign);
    end

endmodule

// File: rtl/alarm_flag_ctl.sv
// Module: alarm_flag_ctl
// Delays the increment strobe by one cycle, then sets the sticky alarm
// flag on a hit. Keeps the timer flag. Control writes AND the flags;
// a set event wins over a clear on the same edge.
module alarm_flag_ctl
    import alarm_irq_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int AW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          all_hit,
    input  logic          tmr_expire,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          tick_q,
    output logic          alarm_flag,
    output logic          timer_flag
);

    logic ctrl_wr;
    logic a_set;
    logic a_keep;
    logic t_keep;

    // Decode write and set conditions.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == SEL_CTRL);
        a_set   = tick_q && all_hit;
        a_keep  = ctrl_wr ? wr_data[CB_AFLAG] : 1'b1;
        t_keep  = ctrl_wr ? wr_data[CB_TFLAG] : 1'b1;
    end

    // Delay the increment strobe so the updated time is compared.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick;
    end

    // Alarm flag: set has priority, else AND with the written bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     alarm_flag <= 1'b0;
        else if (a_set) alarm_flag <= 1'b1;
        else            alarm_flag <= alarm_flag & a_keep;
    end

    // Timer flag: expiry has priority, else AND with the written bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          timer_flag <= 1'b0;
        else if (tmr_expire) timer_flag <= 1'b1;
        else                 timer_flag <= timer_flag & t_keep;
    end

endmodule

// File: rtl/irq_combine.sv
// Module: irq_combine
// Merges flags with enables into the open-drain pull-low request.
// Assumes an external pull-up on the shared interrupt line.
module irq_combine (
    input  logic alarm_flag,
    input  logic timer_flag,
    input  logic aie,
    input  logic tie,
    output logic irq_pull_low
);

    // Pull the line only while an enabled flag is set.
    always_comb begin
        irq_pull_low = (alarm_flag && aie) || (timer_flag && tie);
    end

endmodule

// File: rtl/alarm_irq_unit.sv
// Module: alarm_irq_unit (top)
// Alarm time-match with sticky flag and interrupt request.
// Assumes the time counters update their outputs at the edge that
// samples tick, so the values are valid one cycle after the strobe.
module alarm_irq_unit
    import alarm_irq_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = REG_W,
    parameter int AW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [6:0]    cur_min,
    input  logic [5:0]    cur_hour,
    input  logic [5:0]    cur_day,
    input  logic [2:0]    cur_wday,
    input  logic          tick,
    input  logic          tmr_expire,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          alarm_flag,
    output logic          timer_flag,
    output logic          irq_pull_low
);

    logic [DW-1:0] cur_val [NF];
    logic [DW-1:0] alm_val [NF];
    logic [NF-1:0] alm_ign;
    logic          aie;
    logic          tie;
    logic          all_hit;
    logic          tick_q;

    // Widen the time fields into the uniform compare array.
    always_comb begin
        cur_val[FLD_MIN]  = DW'(cur_min);
        cur_val[FLD_HOUR] = DW'(cur_hour);
        cur_val[FLD_DAY]  = DW'(cur_day);
        cur_val[FLD_WDAY] = DW'(cur_wday);
    end

    alarm_cfg_regs #(.NF(NF), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .alm_val (alm_val),
        .alm_ign (alm_ign),
        .aie     (aie),
        .tie     (tie)
    );

    alarm_field_cmp #(.NF(NF), .DW(DW)) u_cmp (
        .cur_val (cur_val),
        .alm_val (alm_val),
        .alm_ign (alm_ign),
        .all_hit (all_hit)
    );

    alarm_flag_ctl #(.DW(DW), .AW(AW)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .all_hit    (all_hit),
        .tmr_expire (tmr_expire),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tick_q     (tick_q),
        .alarm_flag (alarm_flag),
        .timer_flag (timer_flag)
    );

    irq_combine u_irq (
        .alarm_flag   (alarm_flag),
        .timer_flag   (timer_flag),
        .aie          (aie),
        .tie          (tie),
        .irq_pull_low (irq_pull_low)
    );

endmodule

// File: rtl/alarm_irq_chk.sv
// Module: alarm_irq_chk
// Temporal checks for alarm_irq_unit, attached through bind.
module alarm_irq_chk
    import alarm_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_q,
    input logic             tmr_expire,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_addr,
    input logic [REG_W-1:0] wr_data,
    input logic [NUM_FIELDS-1:0] alm_ign,
    input logic             aie,
    input logic             tie,
    input logic             alarm_flag,
    input logic             timer_flag,
    input logic             irq_pull_low
);

    // R4
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick_q));

    // R5
    no_field_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> !$past(&alm_ign));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alarm_flag) && !($past(wr_en) && $past(wr_addr) == SEL_CTRL))
        |-> alarm_flag);

    // R9
    timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmr_expire) |-> timer_flag);

    // R10
    irq_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!aie && !tie) |-> !irq_pull_low);

    // R10
    irq_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && aie) |-> irq_pull_low);

    // R7
    keep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(timer_flag) && $past(wr_en) && $past(wr_addr) == SEL_CTRL
         && $past(wr_data[CB_TFLAG])) |-> timer_flag);

endmodule

bind alarm_irq_unit alarm_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_q       (tick_q),
    .tmr_expire   (tmr_expire),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .alm_ign      (alm_ign),
    .aie          (aie),
    .tie          (tie),
    .alarm_flag   (alarm_flag),
    .timer_flag   (timer_flag),
    .irq_pull_low (irq_pull_low)
);

// File: tb/tb_alarm_irq_unit.sv
`timescale 1ns/1ps
module tb_alarm_irq_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [5:0] cur_day = '0;
    logic [2:0] cur_wday = '0;
    logic       tick = 1'b0;
    logic       tmr_expire = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       alarm_flag;
    logic       timer_flag;
    logic       irq_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string tag;
        logic  af;
        logic  tf;
        logic  irq;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    alarm_irq_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .cur_wday(cur_wday), .tick(tick), .tmr_expire(tmr_expire),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm_flag(alarm_flag), .timer_flag(timer_flag),
        .irq_pull_low(irq_pull_low)
    );

    // Driver side: queue an expectation for the monitor.
    task automatic expect_now(input string tag, input logic af,
                              input logic tf, input logic irq);
        exp_t e;
        e.tag = tag; e.af = af; e.tf = tf; e.irq = irq;
        sb_q.push_back(e);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Strobe an increment with new time; returns two cycles later.
    task automatic tick_to(input logic [6:0] m, input logic [5:0] h,
                           input logic [5:0] d, input logic [2:0] w);
        cur_min = m; cur_hour = h; cur_day = d; cur_wday = w; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pops expectations and compares shortly after each negedge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (alarm_flag !== e.af || timer_flag !== e.tf ||
                    irq_pull_low !== e.irq) begin
                    errors++;
                    $display("FAIL %s: got af=%b tf=%b irq=%b expected af=%b tf=%b irq=%b",
                             e.tag, alarm_flag, timer_flag, irq_pull_low,
                             e.af, e.tf, e.irq);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 reset", 0, 0, 0);
        @(negedge clk);

        reg_wr(3'd0, 8'h10);              // alarm irq enable
        reg_wr(3'd1, 8'h30);              // minute 30 compared
        expect_now("R1 hour/day/wday ignored so far", 0, 0, 0);

        tick_to(7'h29, 6'h06, 6'h14, 3'd3);
        expect_now("R2 minute mismatch", 0, 0, 0);
        tick_to(7'h30, 6'h06, 6'h14, 3'd3);
        expect_now("R3 minute match sets flag", 1, 0, 1);
        tick_to(7'h31, 6'h06, 6'h14, 3'd3);
        expect_now("R6 flag sticky", 1, 0, 1);

        reg_wr(3'd0, 8'h10);              // clear alarm flag
        expect_now("R6 write clears", 0, 0, 0);
        reg_wr(3'd1, 8'h31);              // matches current minute statically
        @(negedge clk);
        expect_now("R4 static match no set", 0, 0, 0);

        reg_wr(3'd2, 8'h07);              // hour 7 compared
        tick_to(7'h31, 6'h06, 6'h14, 3'd3);
        expect_now("R2 hour mismatch", 0, 0, 0);
        tick_to(7'h31, 6'h07, 6'h14, 3'd3);
        expect_now("R2 minute and hour match", 1, 0, 1);

        reg_wr(3'd0, 8'h10);
        reg_wr(3'd1, 8'h80);              // minute ignored
        reg_wr(3'd2, 8'h80);              // hour ignored
        reg_wr(3'd3, 8'h55);              // day 15, bit 6 outside field
        tick_to(7'h02, 6'h11, 6'h15, 3'd3);
        expect_now("R2 mask and ignored fields", 1, 0, 1);

        tmr_expire = 1'b1;
        @(negedge clk);
        tmr_expire = 1'b0;
        expect_now("R9 timer flag", 1, 1, 1);

        reg_wr(3'd0, 8'h12);              // clear alarm, keep timer
        expect_now("R7 AND keeps timer", 0, 1, 0);
        reg_wr(3'd0, 8'h32);              // timer irq on
        expect_now("R10 timer enable", 0, 1, 1);
        reg_wr(3'd0, 8'h02);              // both enables off
        expect_now("R10 released", 0, 1, 0);
        reg_wr(3'd0, 8'h01);              // clear timer
        expect_now("R7 timer cleared", 0, 0, 0);

        reg_wr(3'd3, 8'h95);              // day ignored: none compared
        tick_to(7'h02, 6'h11, 6'h15, 3'd3);
        expect_now("R5 no field enabled", 0, 0, 0);

        reg_wr(3'd4, 8'h04);              // weekday 4 compared
        tick_to(7'h03, 6'h11, 6'h15, 3'd4);
        expect_now("R2 weekday match", 1, 0, 0);

        // Set event and clearing write on the same edge.
        cur_wday = 3'd4; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        reg_wr(3'd0, 8'h00);
        expect_now("R8 set beats clear", 1, 0, 0);
        reg_wr(3'd0, 8'h00);
        expect_now("R6 later clear", 0, 0, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule